// File: doc/BRIEF.md
# Table and Queue Parameter Decoder

This block turns raw table-base register images and a command-queue base register image into ready-to-use descriptors. One start pulse launches a sequential scan: the eight table-base images are examined one per clock in index order, and each one whose type code names the device table or the collection table rewrites that table's descriptor. The command-queue image is decoded in the cycle after the last table image, and a single-cycle done pulse closes the scan.

Each table descriptor carries a valid flag, the two-level (indirect) flag, the page size in bytes, the entry size in bytes, the capacity in entries, the ID-space limit taken from the feature register, and a 52-bit base address. The command-queue descriptor carries valid, capacity and base address. All descriptors are registered and stay unchanged between scans, so downstream logic can read them at any time after done. Entry sizes are powers of two, so every division is a right shift.

Top module: `tbl_param_decoder`

## Requirements
- R1: After reset every descriptor output, `done_o` and `decode_err_o` read zero.
- R2: Page-size code in image bits 9:8 gives the page size: 0 gives 4096 bytes, 1 gives 16384 bytes, 2 and 3 both give 65536 bytes.
- R3: The type code in image bits 58:56 picks the target: 1 the device table, 4 the collection table. An all-zero image, or any other type code, leaves both table descriptors unchanged.
- R4: Bit 63 is the valid flag and bit 62 the indirect flag. A matching image with bit 63 clear sets its table descriptor to all zeros.
- R5: A flat table holds (size+1) × page ÷ entry entries, where size is image bits 7:0 and entry is the entry size in bytes from image bits 52:48.
- R6: An indirect table holds ((size+1) × page ÷ 8) × (page ÷ entry) entries.
- R7: The device ID limit is 2^(D+1) with D the feature bits 17:13. The collection ID limit is 2^(C+1) with C the feature bits 35:32 when feature bit 36 is set, and 65536 when it is clear.
- R8: For 4 KB and 16 KB pages the base address is image bits 47:12 placed at address bits 47:12. For 64 KB pages, image bits 47:16 go to address bits 47:16 and image bits 15:12 go to address bits 51:48. The low address bits are zero.
- R9: The command-queue image has its size in bits 7:0, its address in bits 51:12 and valid in bit 63. When valid it holds (size+1) × 128 entries at address {bits 51:12, 12'h0}. When invalid its descriptor is zero.
- R10: `done_o` is high for one cycle, exactly nine clock edges after the edge that accepts the start pulse. Images are applied in index order, so a later image of the same type overrides an earlier one.
- R11: A start pulse that arrives while a scan is in progress is ignored and does not shift the done timing.
- R12: A valid matching image whose entry size is zero or not a power of two sets `decode_err_o` and zeroes that table descriptor. The flag is cleared when a start is accepted and otherwise holds.
- R13: Between scans all outputs hold their values, whatever the register inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a scan |
| base_regs_i | input | 512 | Eight 64-bit table-base images, image n at bits 64n+63:64n |
| cmdq_reg_i | input | 64 | Command-queue base image |
| feat_reg_i | input | 64 | Feature register image |
| dev_valid_o | output | 1 | Device table valid |
| dev_indirect_o | output | 1 | Device table two-level |
| dev_page_bytes_o | output | 17 | Device table page size in bytes |
| dev_entry_bytes_o | output | 5 | Device table entry size in bytes |
| dev_max_entries_o | output | 40 | Device table capacity |
| dev_max_ids_o | output | 33 | Device ID limit |
| dev_base_o | output | 52 | Device table base address |
| col_valid_o | output | 1 | Collection table valid |
| col_indirect_o | output | 1 | Collection table two-level |
| col_page_bytes_o | output | 17 | Collection table page size in bytes |
| col_entry_bytes_o | output | 5 | Collection table entry size in bytes |
| col_max_entries_o | output | 40 | Collection table capacity |
| col_max_ids_o | output | 33 | Collection ID limit |
| col_base_o | output | 52 | Collection table base address |
| cmdq_valid_o | output | 1 | Command queue valid |
| cmdq_max_entries_o | output | 16 | Command queue capacity |
| cmdq_base_o | output | 52 | Command queue base address |
| done_o | output | 1 | Scan-complete pulse |
| decode_err_o | output | 1 | Bad entry size seen in this scan |

## Verification
The hardest situations to reach are the ones where two images of one scan collide: a later device image with a bad entry size that wipes out a good earlier one, and a start pulse that lands in the middle of a scan. The stimulus builds image sets for these cases on purpose and checks the result after the scan. It also fires a stray start a few cycles into a scan. Between scans the images are rewritten without a start pulse, to show that the descriptors hold.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  parameter int REG_W    = 64;
  parameter int ADDR_W   = 52;
  parameter int ENT_W    = 40;
  parameter int ID_W     = 33;
  parameter int PAGE_W   = 17;
  parameter int ES_W     = 5;
  parameter int CQ_ENT_W = 16;
  parameter int CQ_SHIFT = 7;   // 4096 / 32 entries per page
  localparam int TYPE_DEV = 1;
  localparam int TYPE_COL = 4;

  typedef struct packed {
    logic              valid;
    logic              indirect;
    logic [PAGE_W-1:0] page_bytes;
    logic [ES_W-1:0]   entry_bytes;
    logic [ENT_W-1:0]  max_entries;
    logic [ID_W-1:0]   max_ids;
    logic [ADDR_W-1:0] base;
  } tbl_desc_t;

  typedef struct packed {
    logic                valid;
    logic [CQ_ENT_W-1:0] max_entries;
    logic [ADDR_W-1:0]   base;
  } cmdq_desc_t;

  function automatic logic [4:0] page_log2(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd12;
      2'd1:    return 5'd14;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [PAGE_W-1:0] page_bytes(input logic [4:0] plog);
    return PAGE_W'(1) << plog;
  endfunction

  function automatic logic entry_is_pow2(input logic [ES_W-1:0] es);
    return (es != '0) && ((es & (es - 1'b1)) == '0);
  endfunction

  function automatic logic [2:0] entry_log2(input logic [ES_W-1:0] es);
    logic [2:0] lg;
    lg = 3'd0;
    for (int b = 0; b < ES_W; b++) begin
      if (es[b]) lg = 3'(b);
    end
    return lg;
  endfunction

  function automatic logic [ENT_W-1:0] flat_cap(input logic [7:0] sz,
                                                input logic [4:0] plog,
                                                input logic [2:0] elog);
    logic [ENT_W-1:0] t;
    t = ENT_W'(sz) + ENT_W'(1);
    t = t << plog;
    return t >> elog;
  endfunction

  function automatic logic [ENT_W-1:0] indirect_cap(input logic [7:0] sz,
                                                    input logic [4:0] plog,
                                                    input logic [2:0] elog);
    logic [ENT_W-1:0] l1;
    logic [ENT_W-1:0] per;
    l1  = ((ENT_W'(sz) + ENT_W'(1)) << plog) >> 3;
    per = (ENT_W'(1) << plog) >> elog;
    return l1 * per;
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_base(input logic [REG_W-1:0] r,
                                                 input logic [1:0] code);
    if (code[1]) return {r[15:12], r[47:16], 16'h0};
    return {4'h0, r[47:12], 12'h0};
  endfunction

  function automatic logic [ID_W-1:0] id_limit(input logic [4:0] bits);
    logic [5:0] sh;
    sh = {1'b0, bits} + 6'd1;
    return ID_W'(1) << sh;
  endfunction

  function automatic logic [CQ_ENT_W-1:0] cmdq_cap(input logic [7:0] sz);
    return (CQ_ENT_W'(sz) + CQ_ENT_W'(1)) << CQ_SHIFT;
  endfunction
endpackage

// File: rtl/tpd_scan_ctrl.sv
module tpd_scan_ctrl #(
  parameter int NUM_BASE = 8,
  localparam int IDX_W = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             scan_vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             cmdq_step_o,
  output logic             done_o
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_CMDQ} state_t;
  state_t state_q;
  logic [IDX_W-1:0] idx_q;
  logic done_q;

  assign accept_o    = (state_q == S_IDLE) && start_i;
  assign busy_o      = (state_q != S_IDLE);
  assign scan_vld_o  = (state_q == S_SCAN);
  assign cmdq_step_o = (state_q == S_CMDQ);
  assign idx_o       = idx_q;
  assign done_o      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_SCAN;
          idx_q   <= '0;
        end
        S_SCAN: begin
          if (idx_q == IDX_W'(NUM_BASE - 1)) state_q <= S_CMDQ;
          else idx_q <= idx_q + 1'b1;
        end
        S_CMDQ: begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_vld_o && idx_q != IDX_W'(NUM_BASE - 1)) |=> (scan_vld_o && idx_q == $past(idx_q) + 1'b1));
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_vld_o && start_i) |=> (busy_o && !done_q));
endmodule

// File: rtl/tpd_table_decode.sv
module tpd_table_decode
  import tpd_pkg::*;
#(
  parameter int TYPE_CODE = TYPE_DEV
) (
  input  logic [REG_W-1:0] reg_i,
  input  logic [ID_W-1:0]  ids_i,
  output logic             match_o,
  output logic             bad_entry_o,
  output tbl_desc_t        desc_o
);
  logic [1:0]      code;
  logic [4:0]      plog;
  logic [ES_W-1:0] es;
  logic [2:0]      elog;
  logic            es_ok;
  logic [7:0]      sz;
  logic            unused_reg_bits;

  assign unused_reg_bits = ^{reg_i[61:59], reg_i[55:53], reg_i[11:10]};

  always_comb begin
    code  = reg_i[9:8];
    sz    = reg_i[7:0];
    plog  = page_log2(code);
    es    = reg_i[52:48];
    es_ok = entry_is_pow2(es);
    elog  = entry_log2(es);
    match_o     = (reg_i != '0) && (reg_i[58:56] == 3'(TYPE_CODE));
    bad_entry_o = reg_i[63] && !es_ok;
    desc_o = '0;
    if (reg_i[63] && es_ok) begin
      desc_o.valid       = 1'b1;
      desc_o.indirect    = reg_i[62];
      desc_o.page_bytes  = page_bytes(plog);
      desc_o.entry_bytes = es;
      desc_o.max_entries = reg_i[62] ? indirect_cap(sz, plog, elog)
                                     : flat_cap(sz, plog, elog);
      desc_o.max_ids     = ids_i;
      desc_o.base        = tbl_base(reg_i, code);
    end
  end
endmodule

// File: rtl/tpd_cmdq_decode.sv
module tpd_cmdq_decode
  import tpd_pkg::*;
(
  input  logic [REG_W-1:0] reg_i,
  output cmdq_desc_t       desc_o
);
  logic unused_reg_bits;
  assign unused_reg_bits = ^{reg_i[62:52], reg_i[11:8]};

  always_comb begin
    desc_o = '0;
    if (reg_i[63]) begin
      desc_o.valid       = 1'b1;
      desc_o.max_entries = cmdq_cap(reg_i[7:0]);
      desc_o.base        = {reg_i[51:12], 12'h0};
    end
  end
endmodule

// File: rtl/tbl_param_decoder.sv
module tbl_param_decoder
  import tpd_pkg::*;
#(
  parameter int NUM_BASE = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [NUM_BASE*REG_W-1:0] base_regs_i,
  input  logic [REG_W-1:0]          cmdq_reg_i,
  input  logic [REG_W-1:0]          feat_reg_i,
  output logic                      dev_valid_o,
  output logic                      dev_indirect_o,
  output logic [PAGE_W-1:0]         dev_page_bytes_o,
  output logic [ES_W-1:0]           dev_entry_bytes_o,
  output logic [ENT_W-1:0]          dev_max_entries_o,
  output logic [ID_W-1:0]           dev_max_ids_o,
  output logic [ADDR_W-1:0]         dev_base_o,
  output logic                      col_valid_o,
  output logic                      col_indirect_o,
  output logic [PAGE_W-1:0]         col_page_bytes_o,
  output logic [ES_W-1:0]           col_entry_bytes_o,
  output logic [ENT_W-1:0]          col_max_entries_o,
  output logic [ID_W-1:0]           col_max_ids_o,
  output logic [ADDR_W-1:0]         col_base_o,
  output logic                      cmdq_valid_o,
  output logic [CQ_ENT_W-1:0]       cmdq_max_entries_o,
  output logic [ADDR_W-1:0]         cmdq_base_o,
  output logic                      done_o,
  output logic                      decode_err_o
);
  localparam int IDX_W   = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1;
  localparam int N_SLOTS = 2;

  logic             accept, busy, scan_vld, cmdq_step;
  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] sel_reg;
  logic [ID_W-1:0]  dev_ids, col_ids;
  logic [N_SLOTS-1:0] slot_bad;
  tbl_desc_t        slot_q [N_SLOTS];
  cmdq_desc_t       cmdq_d, cmdq_q;
  logic             err_q;
  logic             unused_feat_bits;

  assign unused_feat_bits = ^{feat_reg_i[63:37], feat_reg_i[31:18], feat_reg_i[12:0]};

  tpd_scan_ctrl #(.NUM_BASE(NUM_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .accept_o(accept),
    .busy_o(busy), .scan_vld_o(scan_vld), .idx_o(idx),
    .cmdq_step_o(cmdq_step), .done_o(done_o)
  );

  assign sel_reg = base_regs_i[int'(idx)*REG_W +: REG_W];
  assign dev_ids = id_limit(feat_reg_i[17:13]);
  assign col_ids = feat_reg_i[36] ? id_limit({1'b0, feat_reg_i[35:32]})
                                  : (ID_W'(1) << 16);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam int TC = (s == 0) ? TYPE_DEV : TYPE_COL;
    logic      match, bad;
    logic      load;
    tbl_desc_t dec;
    logic [ID_W-1:0] ids;

    if (s == 0) begin : g_dev_ids
      assign ids = dev_ids;
    end else begin : g_col_ids
      assign ids = col_ids;
    end

    tpd_table_decode #(.TYPE_CODE(TC)) u_dec (
      .reg_i(sel_reg), .ids_i(ids), .match_o(match),
      .bad_entry_o(bad), .desc_o(dec)
    );

    assign load        = scan_vld && match;
    assign slot_bad[s] = load && bad;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[s] <= '0;
      else if (load) slot_q[s] <= dec;
    end

    // R4
    desc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q[s].valid |-> (slot_q[s].max_entries != '0 && $onehot0(slot_q[s].page_bytes)
                           && slot_q[s].page_bytes >= PAGE_W'(4096)));
    // R13
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |=> $stable(slot_q[s]));
  end

  tpd_cmdq_decode u_cmdq (.reg_i(cmdq_reg_i), .desc_o(cmdq_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdq_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (cmdq_step) cmdq_q <= cmdq_d;
      if (accept) err_q <= 1'b0;
      else if (|slot_bad) err_q <= 1'b1;
    end
  end

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !accept) |=> err_q);
  // R9
  cmdq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdq_q.valid |-> (cmdq_q.max_entries >= CQ_ENT_W'(128) && cmdq_q.max_entries[6:0] == 7'd0));
  // R10
  done_after_cmdq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(cmdq_step));

  assign dev_valid_o        = slot_q[0].valid;
  assign dev_indirect_o     = slot_q[0].indirect;
  assign dev_page_bytes_o   = slot_q[0].page_bytes;
  assign dev_entry_bytes_o  = slot_q[0].entry_bytes;
  assign dev_max_entries_o  = slot_q[0].max_entries;
  assign dev_max_ids_o      = slot_q[0].max_ids;
  assign dev_base_o         = slot_q[0].base;
  assign col_valid_o        = slot_q[1].valid;
  assign col_indirect_o     = slot_q[1].indirect;
  assign col_page_bytes_o   = slot_q[1].page_bytes;
  assign col_entry_bytes_o  = slot_q[1].entry_bytes;
  assign col_max_entries_o  = slot_q[1].max_entries;
  assign col_max_ids_o      = slot_q[1].max_ids;
  assign col_base_o         = slot_q[1].base;
  assign cmdq_valid_o       = cmdq_q.valid;
  assign cmdq_max_entries_o = cmdq_q.max_entries;
  assign cmdq_base_o        = cmdq_q.base;
  assign decode_err_o       = err_q;
endmodule

// File: tb/tbl_param_decoder_tb.sv
module tbl_param_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [511:0] base_regs = '0;
  logic [63:0] cmdq_reg = '0;
  logic [63:0] feat = '0;
  logic dev_v, dev_i, col_v, col_i, cq_v, done, err;
  logic [16:0] dev_pg, col_pg;
  logic [4:0]  dev_es, col_es;
  logic [39:0] dev_ne, col_ne;
  logic [32:0] dev_id, col_id;
  logic [51:0] dev_b, col_b, cq_b;
  logic [15:0] cq_ne;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbl_param_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_regs_i(base_regs),
    .cmdq_reg_i(cmdq_reg), .feat_reg_i(feat),
    .dev_valid_o(dev_v), .dev_indirect_o(dev_i), .dev_page_bytes_o(dev_pg),
    .dev_entry_bytes_o(dev_es), .dev_max_entries_o(dev_ne), .dev_max_ids_o(dev_id),
    .dev_base_o(dev_b), .col_valid_o(col_v), .col_indirect_o(col_i),
    .col_page_bytes_o(col_pg), .col_entry_bytes_o(col_es), .col_max_entries_o(col_ne),
    .col_max_ids_o(col_id), .col_base_o(col_b), .cmdq_valid_o(cq_v),
    .cmdq_max_entries_o(cq_ne), .cmdq_base_o(cq_b), .done_o(done), .decode_err_o(err)
  );

  // Reference model state: slot 0 device, slot 1 collection
  longint unsigned m_v[2], m_ind[2], m_pg[2], m_es[2], m_ne[2], m_id[2], m_b[2];
  longint unsigned m_cqv, m_cqn, m_cqb;
  bit m_busy, m_done, m_err;
  int m_cnt;

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic void model_table(longint unsigned r);
    int typ, s;
    longint unsigned es, pg, sz;
    typ = int'((r >> 56) % 8);
    if (r == 0 || !(typ == 1 || typ == 4)) return;
    s = (typ == 1) ? 0 : 1;
    m_v[s] = 0; m_ind[s] = 0; m_pg[s] = 0; m_es[s] = 0; m_ne[s] = 0; m_id[s] = 0; m_b[s] = 0;
    if (r[63] == 1'b0) return;
    es = (r >> 48) % 32;
    if (!(es == 1 || es == 2 || es == 4 || es == 8 || es == 16)) begin
      m_err = 1;
      return;
    end
    case ((r >> 8) % 4)
      0: pg = 4096;
      1: pg = 16384;
      default: pg = 65536;
    endcase
    sz = (r % 256) + 1;
    m_v[s] = 1;
    m_ind[s] = r[62];
    m_pg[s] = pg;
    m_es[s] = es;
    m_ne[s] = r[62] ? ((sz * pg / 8) * (pg / es)) : (sz * pg / es);
    if (s == 0) m_id[s] = 2 ** (((feat >> 13) % 32) + 1);
    else m_id[s] = feat[36] ? 2 ** (((feat >> 32) % 16) + 1) : 65536;
    if (pg == 65536)
      m_b[s] = ((r >> 16) % (64'd1 << 32)) * 65536 + ((r >> 12) % 16) * (64'd1 << 48);
    else
      m_b[s] = ((r >> 12) % (64'd1 << 36)) * 4096;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_v[s] = 0; m_ind[s] = 0; m_pg[s] = 0; m_es[s] = 0; m_ne[s] = 0; m_id[s] = 0; m_b[s] = 0;
      end
      m_cqv = 0; m_cqn = 0; m_cqb = 0;
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt < 8) begin
          model_table(base_regs[m_cnt*64 +: 64]);
          m_cnt++;
        end else begin
          m_cqv = cmdq_reg[63];
          m_cqn = cmdq_reg[63] ? ((cmdq_reg % 256) + 1) * 4096 / 32 : 0;
          m_cqb = cmdq_reg[63] ? ((cmdq_reg >> 12) % (64'd1 << 40)) * 4096 : 0;
          m_busy = 0;
          m_done = 1;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_err = 0;
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 dev valid", dev_v, m_v[0]);
      chk("R4 dev indirect", dev_i, m_ind[0]);
      chk("R2 dev page", dev_pg, m_pg[0]);
      chk("R12 dev entry", dev_es, m_es[0]);
      chk("R5/R6 dev entries", dev_ne, m_ne[0]);
      chk("R7 dev ids", dev_id, m_id[0]);
      chk("R8 dev base", dev_b, m_b[0]);
      chk("R4 col valid", col_v, m_v[1]);
      chk("R4 col indirect", col_i, m_ind[1]);
      chk("R2 col page", col_pg, m_pg[1]);
      chk("R12 col entry", col_es, m_es[1]);
      chk("R5/R6 col entries", col_ne, m_ne[1]);
      chk("R7 col ids", col_id, m_id[1]);
      chk("R8 col base", col_b, m_b[1]);
      chk("R9 cmdq valid", cq_v, m_cqv);
      chk("R9 cmdq entries", cq_ne, m_cqn);
      chk("R9 cmdq base", cq_b, m_cqb);
      chk("R10 done", done, m_done);
      chk("R12 error", err, m_err);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] mk(bit v, bit ind, int typ, int es, int code, int size,
                                     logic [35:0] p);
    logic [63:0] r;
    r = '0;
    r[63] = v; r[62] = ind; r[58:56] = 3'(typ); r[52:48] = 5'(es);
    r[47:12] = p; r[9:8] = 2'(code); r[7:0] = 8'(size);
    return r;
  endfunction

  task automatic set_reg(int i, logic [63:0] v);
    base_regs[i*64 +: 64] = v;
  endtask

  // Runs one scan; optional stray start at the given negedge count
  task automatic run_scan(int stray_at);
    int k;
    @(negedge clk); start = 1'b1;
    k = 0;
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      start = (j == stray_at) ? 1'b1 : 1'b0;
      k = j;
      if (done) break;
    end
    start = 1'b0;
    chk(stray_at > 0 ? "R11 done timing with stray start" : "R10 done timing", k, 10);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {dev_v, col_v, cq_v}, 0);
    chk("R1 reset done/err", {done, err}, 0);
    chk("R1 reset bases", dev_b | col_b | cq_b, 0);
    rst_n = 1'b1;

    // Scenario A: flat tables, 4K and 16K, feature bit 36 clear
    feat = '0; feat[17:13] = 5'd15; feat[35:32] = 4'd7;
    set_reg(0, mk(1, 0, 1, 8, 0, 3, 36'h0_1234_5678));
    set_reg(3, mk(1, 0, 4, 16, 1, 0, 36'h0_0000_0ABC));
    set_reg(5, mk(1, 0, 2, 8, 0, 7, 36'h0_0000_0FFF));
    cmdq_reg = '0; cmdq_reg[63] = 1'b1; cmdq_reg[51:12] = 40'h12_3456_789A; cmdq_reg[7:0] = 8'd15;
    run_scan(0);
    chk("R2 4K page", dev_pg, 4096);
    chk("R2 16K page", col_pg, 16384);
    chk("R5 flat dev entries", dev_ne, 2048);
    chk("R5 flat col entries", col_ne, 1024);
    chk("R7 dev ids", dev_id, 65536);
    chk("R7 col ids with bit 36 clear", col_id, 65536);
    chk("R8 4K base", dev_b, 52'h0_1234_5678_000);
    chk("R9 cmdq entries", cq_ne, 2048);
    chk("R9 cmdq base", cq_b, 52'h1_2345_6789_A000);

    // Scenario B: later image overrides, bad entry size, invalid images
    base_regs = '0;
    set_reg(0, mk(1, 0, 1, 8, 0, 3, 36'h1));
    set_reg(2, mk(1, 0, 1, 6, 0, 3, 36'h2));
    set_reg(4, mk(1, 0, 4, 8, 1, 3, 36'h3));
    set_reg(7, mk(0, 1, 4, 8, 1, 3, 36'h4));
    cmdq_reg = 64'h0000_0ABC_DEF0_00FF;
    run_scan(0);
    chk("R12 error flag", err, 1);
    chk("R12 dev cleared by bad entry", dev_v, 0);
    chk("R4 col cleared by invalid image", col_b | col_ne, 0);
    chk("R9 invalid cmdq cleared", cq_ne, 0);

    // Scenario C: 64K and indirect, feature bit 36 set, page code 3
    base_regs = '0;
    feat[36] = 1'b1;
    set_reg(1, mk(1, 1, 1, 4, 2, 1, 36'hABCD_1234_A));
    set_reg(6, mk(1, 1, 4, 16, 3, 0, 36'h0_0001_0005));
    cmdq_reg = '0; cmdq_reg[63] = 1'b1; cmdq_reg[7:0] = 8'd255;
    run_scan(0);
    chk("R12 error cleared by new scan", err, 0);
    chk("R2 code 3 page", col_pg, 65536);
    chk("R6 indirect dev entries", dev_ne, 268435456);
    chk("R6 indirect col entries", col_ne, 33554432);
    chk("R7 col ids with bit 36 set", col_id, 256);
    chk("R8 64K base", dev_b, 52'hA_ABCD_1234_0000);
    chk("R9 cmdq max size", cq_ne, 32768);

    // Scenario D: only ignored types and zero images, stray start mid-scan
    base_regs = '0;
    set_reg(2, mk(1, 0, 2, 8, 0, 3, 36'h5));
    set_reg(5, mk(1, 0, 7, 8, 0, 3, 36'h6));
    run_scan(4);
    chk("R3 dev unchanged by other types", dev_b, 52'hA_ABCD_1234_0000);
    chk("R3 col unchanged by other types", col_ne, 33554432);

    // Inputs change without a start: descriptors hold
    set_reg(0, mk(1, 0, 1, 8, 0, 0, 36'h7));
    cmdq_reg = '0;
    feat = '0;
    repeat (15) @(negedge clk);
    chk("R13 dev base holds", dev_b, 52'hA_ABCD_1234_0000);
    chk("R13 cmdq holds", cq_ne, 32768);
    chk("R13 no done without start", done, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule